// File: doc/BRIEF.md
# Burst SPI Master with Chip-Select Sequencing

This block is an SPI master (mode 0, MSB first) that moves one burst of a programmable number of bits, from 1 to 4096, out of a 32-bit transmit FIFO. Received bits go into a 32-bit receive FIFO. Chip select is driven low for the whole burst. This holds even when the burst spans several FIFO words, so a peripheral such as a converter that needs a 24-bit frame sees a single unbroken selection.

A burst can start in one of two ways. In strobe mode the master starts on a one-cycle exchange strobe. In auto mode it starts as soon as the transmit FIFO holds a word. A programmable setup delay separates the falling edge of chip select from the first clock edge. A second waveform mode negates chip select after every burst and holds it high for a programmable idle gap. In that mode the master reselects automatically for as long as the FIFO has data. The serial clock is the system clock divided by 2×(div+1). If the FIFO runs dry in the middle of a burst, the clock stops with chip select still low and resumes when data arrives.

Top module: `burst_spi_master`

## Requirements
- R1: After reset, cs_n=1, sclk=0, mosi=0, busy=0, rx_empty=1 and tx_full=0.
- R2: cfg_burst_len is a 12-bit field holding bits−1. A burst produces exactly cfg_burst_len+1 rising sclk edges while cs_n is low, up to 4096 edges.
- R3: Bits leave MSB first. The first FIFO word of a burst supplies only its low (len mod 32)+1 bits, and every later word supplies all 32. Received bits are packed the same way, so a partial first receive word sits in the low-order bits. mosi changes only while sclk is low.
- R4: With cfg_cs_per_burst=0, cs_n stays low from the first to the last bit, across FIFO word boundaries. One strobe gives one burst, even if the FIFO holds more words.
- R5: With cfg_auto_start=0, a burst starts only on xch_set while the master is idle. A strobe while busy=1 has no effect.
- R6: With cfg_auto_start=1, a burst starts without a strobe once the transmit FIFO is non-empty.
- R7: When data is present at start, the first rising sclk edge comes exactly cfg_cs_delay+cfg_clk_div+2 clock cycles after cs_n falls.
- R8: While shifting, sclk is high for cfg_clk_div+1 cycles and low for cfg_clk_div+1 cycles per bit.
- R9: With cfg_cs_per_burst=1, cs_n rises after every burst and stays high for exactly cfg_idle_gap+1 cycles. It then falls again for the next burst while the FIFO holds data, so one strobe can send several bursts.
- R10: busy is 1 from the start of a burst until cs_n has been negated and the idle gap has elapsed. cs_n low always implies busy=1.
- R11: If the transmit FIFO is empty when the next word is needed, sclk stays low and cs_n stays low until a word is written. The burst then completes with the correct data.
- R12: sclk is low whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 12 | Burst bit count minus one |
| cfg_auto_start | input | 1 | 1: start on FIFO data, 0: start on strobe |
| cfg_cs_per_burst | input | 1 | 1: negate chip select after every burst |
| cfg_cs_delay | input | 8 | Extra setup cycles between CS fall and clocking |
| cfg_idle_gap | input | 8 | CS high time between bursts, minus one |
| cfg_clk_div | input | 8 | Half-period of sclk in cycles, minus one |
| xch_set | input | 1 | Exchange strobe |
| busy | output | 1 | Exchange in progress (exchange bit readback) |
| tx_wr | input | 1 | Transmit FIFO write |
| tx_data | input | 32 | Transmit FIFO write data |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Receive FIFO read |
| rx_data | output | 32 | Receive FIFO head word |
| rx_empty | output | 1 | Receive FIFO empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The checker takes some input behaviour for granted. The transmit FIFO is never written while full, the receive FIFO is never read while empty, and the configuration fields are held steady while busy is high. The stimulus respects all three. Every write waits for tx_full to drop, every read first looks at rx_empty, and configuration changes are made only after busy has been seen low. The serial peripheral model in the bench samples mosi on rising sclk and changes miso only after a rising edge. The master's sampling point therefore always sees a settled value.

// File: rtl/bspi_pkg.sv
package bspi_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 12;
    localparam int CNT_W  = 8;
    localparam int BP_W   = $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } bspi_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] burst_len;
        logic             auto_start;
        logic             cs_per_burst;
        logic [CNT_W-1:0] cs_delay;
        logic [CNT_W-1:0] idle_gap;
        logic [CNT_W-1:0] clk_div;
    } bspi_cfg_t;

    // Bit index inside the first word of a burst (partial word uses low bits)
    function automatic logic [BP_W-1:0] first_bit_idx(input logic [LEN_W-1:0] len);
        return len[BP_W-1:0];
    endfunction

endpackage

// File: rtl/bspi_fifo.sv
module bspi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/bspi_engine.sv
module bspi_engine
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bspi_cfg_t         cfg,
    input  logic              xch_set,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              miso,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy
);
    bspi_state_e       state;
    logic [CNT_W-1:0]  dly, gcnt, hc;
    logic [LEN_W-1:0]  rem;
    logic [BP_W-1:0]   bitpos;
    logic [WORD_W-1:0] sh, rx_sh, rx_next;
    logic              load_req, start_idle, restart;

    always_comb begin
        load_req = (state == ST_FETCH)
                || (state == ST_SETUP && dly == '0)
                || (state == ST_HIGH && hc == '0 && rem != '0 && bitpos == '0);
        tx_pop     = load_req && tx_valid;
        start_idle = (state == ST_IDLE) && (cfg.auto_start ? tx_valid : xch_set);
        restart    = tx_valid && (cfg.auto_start || cfg.cs_per_burst);
        rx_next    = {rx_sh[WORD_W-2:0], miso};
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dly     <= '0;
            gcnt    <= '0;
            hc      <= '0;
            rem     <= '0;
            bitpos  <= '0;
            sh      <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
            rx_push <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            rx_push <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_idle) begin
                        cs_n   <= 1'b0;
                        state  <= ST_SETUP;
                        dly    <= cfg.cs_delay;
                        rem    <= cfg.burst_len;
                        bitpos <= first_bit_idx(cfg.burst_len);
                        rx_sh  <= '0;
                    end
                end
                ST_SETUP: begin
                    if (dly != '0) begin
                        dly <= dly - CNT_W'(1);
                    end else if (tx_valid) begin
                        sh    <= tx_word;
                        mosi  <= tx_word[bitpos];
                        hc    <= cfg.clk_div;
                        state <= ST_LOW;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (tx_valid) begin
                        sh    <= tx_word;
                        mosi  <= tx_word[bitpos];
                        hc    <= cfg.clk_div;
                        state <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (hc != '0) begin
                        hc <= hc - CNT_W'(1);
                    end else begin
                        sclk  <= 1'b1;
                        hc    <= cfg.clk_div;
                        state <= ST_HIGH;
                        if (bitpos == '0) begin
                            rx_word <= rx_next;
                            rx_push <= 1'b1;
                            rx_sh   <= '0;
                        end else begin
                            rx_sh <= rx_next;
                        end
                    end
                end
                ST_HIGH: begin
                    if (hc != '0) begin
                        hc <= hc - CNT_W'(1);
                    end else begin
                        sclk <= 1'b0;
                        if (rem == '0) begin
                            cs_n  <= 1'b1;
                            mosi  <= 1'b0;
                            gcnt  <= cfg.idle_gap;
                            state <= ST_GAP;
                        end else begin
                            rem <= rem - LEN_W'(1);
                            if (bitpos == '0) begin
                                bitpos <= BP_W'(WORD_W-1);
                                if (tx_valid) begin
                                    sh    <= tx_word;
                                    mosi  <= tx_word[WORD_W-1];
                                    hc    <= cfg.clk_div;
                                    state <= ST_LOW;
                                end else begin
                                    state <= ST_FETCH;
                                end
                            end else begin
                                bitpos <= bitpos - BP_W'(1);
                                mosi   <= sh[bitpos - BP_W'(1)];
                                hc     <= cfg.clk_div;
                                state  <= ST_LOW;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt != '0) begin
                        gcnt <= gcnt - CNT_W'(1);
                    end else if (restart) begin
                        cs_n   <= 1'b0;
                        state  <= ST_SETUP;
                        dly    <= cfg.cs_delay;
                        rem    <= cfg.burst_len;
                        bitpos <= first_bit_idx(cfg.burst_len);
                        rx_sh  <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/burst_spi_master.sv
module burst_spi_master
    import bspi_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_burst_len,
    input  logic              cfg_auto_start,
    input  logic              cfg_cs_per_burst,
    input  logic [CNT_W-1:0]  cfg_cs_delay,
    input  logic [CNT_W-1:0]  cfg_idle_gap,
    input  logic [CNT_W-1:0]  cfg_clk_div,
    input  logic              xch_set,
    output logic              busy,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    bspi_cfg_t         cfg;
    logic              tx_empty, tx_pop, rx_push, rx_full_unused;
    logic [WORD_W-1:0] tx_head, rx_word;

    always_comb begin
        cfg.burst_len    = cfg_burst_len;
        cfg.auto_start   = cfg_auto_start;
        cfg.cs_per_burst = cfg_cs_per_burst;
        cfg.cs_delay     = cfg_cs_delay;
        cfg.idle_gap     = cfg_idle_gap;
        cfg.clk_div      = cfg_clk_div;
    end

    bspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_wr), .push_data(tx_data),
        .pop(tx_pop), .head(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    bspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_rd), .head(rx_data),
        .full(rx_full_unused), .empty(rx_empty)
    );

    bspi_engine u_eng (
        .clk(clk), .rst(rst), .cfg(cfg), .xch_set(xch_set),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .miso(miso), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
    );
endmodule

// File: rtl/bspi_checker.sv
module bspi_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic tx_wr,
    input logic tx_full,
    input logic rx_rd,
    input logic rx_empty
);
    a_r12_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r10_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    a_r3_mosi_stable_in_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r4_release_with_clock_low: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !sclk);

    a_r10_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    a_env_no_tx_overflow: assert property (@(posedge clk) disable iff (rst)
        !(tx_wr && tx_full));

    a_env_no_rx_underflow: assert property (@(posedge clk) disable iff (rst)
        !(rx_rd && rx_empty));
endmodule

bind burst_spi_master bspi_checker u_chk (.*);

// File: tb/burst_spi_master_test.sv
module burst_spi_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg_burst_len = '0;
    logic        cfg_auto_start = 1'b0;
    logic        cfg_cs_per_burst = 1'b0;
    logic [7:0]  cfg_cs_delay = '0;
    logic [7:0]  cfg_idle_gap = '0;
    logic [7:0]  cfg_clk_div = '0;
    logic        xch_set = 1'b0;
    logic        busy;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_full;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_data;
    logic        rx_empty;
    logic        sclk, mosi, miso, cs_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_spi_master uut (.*);

    // Serial peripheral model
    localparam logic [63:0] PAT = 64'hC3A5_0F96_5A3C_E187;
    int          bits_seen = 0;
    int          cs_falls = 0;
    logic [63:0] cap = '0;
    logic [63:0] pat_sh = PAT;
    assign miso = pat_sh[63];

    always @(posedge sclk or negedge cs_n) begin
        if (sclk) begin
            bits_seen = bits_seen + 1;
            cap = {cap[62:0], mosi};
            pat_sh = {pat_sh[62:0], 1'b0};
        end else begin
            cs_falls = cs_falls + 1;
            pat_sh = PAT;
        end
    end

    // Cycle-domain timing monitor
    int hi_run = 0, lo_run = 0, gap_run = 0;
    int last_hi = 0, last_lo = 0, last_gap = 0;
    bit lo_track = 1'b0;
    always @(negedge clk) begin
        if (cs_n) begin
            lo_track = 1'b0;
            if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
            if (busy) gap_run = gap_run + 1;
        end else begin
            if (gap_run != 0) begin last_gap = gap_run; gap_run = 0; end
            if (sclk) begin
                if (lo_track) begin last_lo = lo_run; lo_track = 1'b0; end
                hi_run = hi_run + 1;
            end else begin
                if (hi_run != 0) begin
                    last_hi = hi_run; hi_run = 0; lo_track = 1'b1; lo_run = 0;
                end
                if (lo_track) lo_run = lo_run + 1;
            end
        end
        if (!busy) gap_run = 0;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [11:0] len, input logic au, input logic wv,
                           input logic [7:0] dl, input logic [7:0] gp, input logic [7:0] dv);
        @(negedge clk);
        cfg_burst_len = len; cfg_auto_start = au; cfg_cs_per_burst = wv;
        cfg_cs_delay = dl; cfg_idle_gap = gp; cfg_clk_div = dv;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_data = w; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        xch_set = 1'b1;
        @(negedge clk);
        xch_set = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic pop_rx(input string req, input logic [31:0] exp);
        @(negedge clk);
        chk({req, " rx available"}, {63'd0, rx_empty}, 64'd0);
        if (!rx_empty) begin
            chk({req, " rx word"}, {32'd0, rx_data}, {32'd0, exp});
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", {63'd0, cs_n}, 64'd1);
        chk("R1 sclk", {63'd0, sclk}, 64'd0);
        chk("R1 mosi", {63'd0, mosi}, 64'd0);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 rx_empty", {63'd0, rx_empty}, 64'd1);
        chk("R1 tx_full", {63'd0, tx_full}, 64'd0);
    endtask

    task automatic t_byte();
        int b0, f0;
        set_cfg(12'd7, 0, 0, 8'd2, 8'd1, 8'd1);
        b0 = bits_seen; f0 = cs_falls;
        push_word(32'h0000_00A5);
        strobe();
        wait_idle();
        chk("R2 8-bit count", 64'(bits_seen - b0), 64'd8);
        chk("R3 8-bit data", {56'd0, cap[7:0]}, 64'hA5);
        chk("R4 8-bit one select", 64'(cs_falls - f0), 64'd1);
        pop_rx("R3 8-bit", 32'h0000_00C3);
    endtask

    task automatic t_24bit();
        int b0, f0;
        set_cfg(12'h017, 0, 0, 8'd1, 8'd1, 8'd0);
        b0 = bits_seen; f0 = cs_falls;
        push_word(32'h77AB_CDEF);
        strobe();
        wait_idle();
        chk("R2 24-bit count", 64'(bits_seen - b0), 64'd24);
        chk("R3 24-bit low bits only", {40'd0, cap[23:0]}, 64'hABCDEF);
        chk("R4 24-bit one select", 64'(cs_falls - f0), 64'd1);
        pop_rx("R3 24-bit", 32'h00C3_A50F);
    endtask

    task automatic t_two_words();
        int b0, f0;
        set_cfg(12'd39, 0, 0, 8'd0, 8'd1, 8'd1);
        b0 = bits_seen; f0 = cs_falls;
        push_word(32'hFFFF_FF12);
        push_word(32'h3456_789A);
        strobe();
        wait_idle();
        chk("R2 40-bit count", 64'(bits_seen - b0), 64'd40);
        chk("R3 40-bit data", {24'd0, cap[39:0]}, 64'h12_3456_789A);
        chk("R4 CS held across words", 64'(cs_falls - f0), 64'd1);
        pop_rx("R3 40-bit first", 32'h0000_00C3);
        pop_rx("R3 40-bit second", 32'hA50F_965A);
    endtask

    task automatic t_timing();
        int n = 0;
        set_cfg(12'd15, 0, 0, 8'd5, 8'd1, 8'd3);
        push_word(32'h0000_F00F);
        strobe();
        while (cs_n && n < 100) begin @(negedge clk); n++; end
        n = 0;
        while (!sclk && n < 100) begin @(negedge clk); n++; end
        chk("R7 CS to first SCLK", 64'(n), 64'd10);
        wait_idle();
        chk("R8 SCLK high time", 64'(last_hi), 64'd4);
        chk("R8 SCLK low time", 64'(last_lo), 64'd4);
        chk("R3 16-bit data", {48'd0, cap[15:0]}, 64'hF00F);
        pop_rx("R3 16-bit", 32'h0000_C3A5);
    endtask

    task automatic t_auto();
        int f0;
        set_cfg(12'd7, 1, 0, 8'd0, 8'd1, 8'd0);
        f0 = cs_falls;
        repeat (5) @(negedge clk);
        chk("R6 no start on empty FIFO", {63'd0, busy}, 64'd0);
        push_word(32'h0000_003C);
        repeat (3) @(negedge clk);
        wait_idle();
        chk("R6 auto start select", 64'(cs_falls - f0), 64'd1);
        chk("R6 auto start data", {56'd0, cap[7:0]}, 64'h3C);
        pop_rx("R6 auto", 32'h0000_00C3);
        set_cfg(12'd7, 0, 0, 8'd0, 8'd1, 8'd0);
    endtask

    task automatic t_per_burst();
        int b0, f0;
        set_cfg(12'd7, 0, 1, 8'd0, 8'd3, 8'd0);
        b0 = bits_seen; f0 = cs_falls;
        push_word(32'h0000_0011);
        push_word(32'h0000_0022);
        push_word(32'h0000_0033);
        strobe();
        wait_idle();
        chk("R9 three selections", 64'(cs_falls - f0), 64'd3);
        chk("R9 total bits", 64'(bits_seen - b0), 64'd24);
        chk("R9 data", {40'd0, cap[23:0]}, 64'h112233);
        chk("R9 idle gap", 64'(last_gap), 64'd4);
        for (int i = 0; i < 3; i++) pop_rx("R9 per-burst rx", 32'h0000_00C3);
    endtask

    task automatic t_single_and_ignore();
        int f0;
        set_cfg(12'd23, 0, 0, 8'd0, 8'd1, 8'd1);
        f0 = cs_falls;
        push_word(32'h00AA_BBCC);
        push_word(32'h00DD_EEFF);
        strobe();
        repeat (10) @(negedge clk);
        chk("R10 busy mid burst", {63'd0, busy}, 64'd1);
        strobe();
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R5 strobe while busy ignored", 64'(cs_falls - f0), 64'd1);
        chk("R4 one burst per strobe data", {40'd0, cap[23:0]}, 64'hAABBCC);
        chk("R10 idle after burst", {62'd0, busy, cs_n}, 64'd1);
        strobe();
        wait_idle();
        chk("R5 next strobe sends queued word", {40'd0, cap[23:0]}, 64'hDDEEFF);
        chk("R5 second selection", 64'(cs_falls - f0), 64'd2);
        pop_rx("R5 first", 32'h00C3_A50F);
        pop_rx("R5 second", 32'h00C3_A50F);
    endtask

    task automatic t_stall();
        int b0, f0;
        set_cfg(12'd39, 0, 0, 8'd0, 8'd1, 8'd0);
        b0 = bits_seen; f0 = cs_falls;
        strobe();
        repeat (30) @(negedge clk);
        chk("R11 start stall bits", 64'(bits_seen - b0), 64'd0);
        chk("R11 start stall cs/sclk", {62'd0, cs_n, sclk}, 64'd0);
        push_word(32'h0000_005A);
        repeat (60) @(negedge clk);
        chk("R11 mid stall bits", 64'(bits_seen - b0), 64'd8);
        chk("R11 mid stall cs/sclk", {62'd0, cs_n, sclk}, 64'd0);
        push_word(32'hCAFE_F00D);
        wait_idle();
        chk("R11 resumed bits", 64'(bits_seen - b0), 64'd40);
        chk("R11 resumed data", {24'd0, cap[39:0]}, 64'h5A_CAFE_F00D);
        chk("R11 one selection", 64'(cs_falls - f0), 64'd1);
        pop_rx("R11 first", 32'h0000_00C3);
        pop_rx("R11 second", 32'hA50F_965A);
    endtask

    task automatic t_max();
        int b0, f0;
        set_cfg(12'hFFF, 0, 0, 8'd0, 8'd1, 8'd0);
        b0 = bits_seen; f0 = cs_falls;
        strobe();
        for (int i = 0; i < 128; i++) push_word(32'(i));
        wait_idle();
        chk("R2 4096-bit count", 64'(bits_seen - b0), 64'd4096);
        chk("R2 4096-bit one selection", 64'(cs_falls - f0), 64'd1);
        chk("R3 4096-bit tail data", cap, {32'd126, 32'd127});
        @(negedge clk);
        while (!rx_empty) begin
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte();
        t_24bit();
        t_two_words();
        t_timing();
        t_auto();
        t_per_burst();
        t_single_and_ignore();
        t_stall();
        t_max();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule